// File: doc/BRIEF.md
# Filtered external interrupt edge detector

This block is the front end for sixteen external interrupt pins. Each pin is brought into the system clock domain by a two-stage synchronizer and then goes through a digital glitch filter. The filter accepts a new level only after the synchronized pin has shown it for a programmable number of consecutive clocks. When the filtered level of a pin changes, the change is an edge. If that direction is enabled for that pin, the edge sets a sticky event flag.

Software controls the block through a single-cycle register port that has an address, a write strobe, write data and combinational read data. There are two independent per-pin enable masks, one for rising edges and one for falling edges. When both bits are set for a pin, that pin reports edges in both directions. A 4-bit filter length is shared by all pins. The event flags are cleared by writing ones to them. The interrupt request output is high whenever any flag is set.

Top module: `irqf_top`

## Requirements
- R1: After reset, all four registers read zero and `irq_o` is low.
- R2: The rising-enable register at byte offset 0x28 and the falling-enable register at 0x2C each hold bit n for pin n in bits 15:0. Bits 31:16 read zero and ignore writes.
- R3: The filter length L sits in bits 3:0 of the register at offset 0x34. Bits 31:4 read zero.
- R4: A synchronized pin level that differs from the filtered level for fewer than L+1 consecutive clocks produces no edge and sets no flag.
- R5: A pin that changes between two clock edges and then holds its new level sets its flag on the (L+3)-th rising clock edge counted from the change. With L=0, a pulse covering one clock edge is accepted.
- R6: A rising edge sets flag n only if rising-enable bit n is 1. A falling edge sets flag n only if falling-enable bit n is 1. With both bits set, both directions set the flag.
- R7: The event flags at offset 0x30 (bit n for pin n) stay set until cleared. Writing 1 to a bit clears it, and writing 0 has no effect.
- R8: If a flag is set by an edge in the same cycle that a write clears it, the flag ends up set.
- R9: `irq_o` is high exactly when at least one event flag is set. Rewriting the enable registers never clears flags that are already set.
- R10: Reads of any other offset return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 16 | Asynchronous external interrupt pins |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A filter counter that is off by one shows up in the cycle the flag register changes. A pulse of exactly L clocks must leave the flags at zero, and a pulse of L+1 clocks must set them on clock edge L+3. Reading the flags one cycle before and one cycle after that edge exposes the error right away. A wrong flag-update rule shows up on the next read of offset 0x30, one cycle after the write or edge that caused it. Examples are a clear that overrides a simultaneous set, an edge that sets a flag whose direction is disabled, and a write of zero that clears a flag.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int CH_N    = 16;
    localparam int LEN_W   = 4;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int OFF_REN = 'h28;
    localparam int OFF_FEN = 'h2C;
    localparam int OFF_EVT = 'h30;
    localparam int OFF_FLT = 'h34;
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/irqf_filter.sv
module irqf_filter #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [LEN_W-1:0] flen,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic             level;
        logic [LEN_W-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        fall = 1'b0;
        if (sample == st_q.level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= flen) begin
            st_d.level = sample;
            st_d.cnt   = '0;
            rise       = sample;
            fall       = ~sample;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a sample equal to the filtered level restarts the count, level holds
    a_r4_match_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (sample == st_q.level) |=> (st_q.cnt == '0) && $stable(st_q.level));

    // R5: the filtered level moves only once the count has reached the length
    a_r5_accept_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.level == $past(st_q.level)) || ($past(st_q.cnt) >= $past(flen)));

    // R6: one edge direction at a time per pin
    a_r6_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall}));
endmodule

// File: rtl/irqf_regs.sv
module irqf_regs
    import irqf_pkg::*;
#(
    parameter int CH   = CH_N,
    parameter int LW   = LEN_W,
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [CH-1:0] rise_ev,
    input  logic [CH-1:0] fall_ev,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] flen,
    output logic          irq
);
    localparam logic [AW-1:0] A_REN = AW'(OFF_REN);
    localparam logic [AW-1:0] A_FEN = AW'(OFF_FEN);
    localparam logic [AW-1:0] A_EVT = AW'(OFF_EVT);
    localparam logic [AW-1:0] A_FLT = AW'(OFF_FLT);

    typedef struct packed {
        logic [CH-1:0] ren;
        logic [CH-1:0] fen;
        logic [CH-1:0] flags;
        logic [LW-1:0] flen;
    } regs_st_t;

    regs_st_t r_d, r_q;
    logic [CH-1:0] set_v;
    logic [CH-1:0] clr_v;
    logic          unused_hi;

    assign unused_hi = ^wdata[DW-1:CH];

    always_comb begin
        r_d   = r_q;
        set_v = (rise_ev & r_q.ren) | (fall_ev & r_q.fen);
        clr_v = (we && addr == A_EVT) ? wdata[CH-1:0] : '0;
        if (we && addr == A_REN) r_d.ren  = wdata[CH-1:0];
        if (we && addr == A_FEN) r_d.fen  = wdata[CH-1:0];
        if (we && addr == A_FLT) r_d.flen = wdata[LW-1:0];
        r_d.flags = (r_q.flags & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (addr)
            A_REN:   rdata = {{(DW-CH){1'b0}}, r_q.ren};
            A_FEN:   rdata = {{(DW-CH){1'b0}}, r_q.fen};
            A_EVT:   rdata = {{(DW-CH){1'b0}}, r_q.flags};
            A_FLT:   rdata = {{(DW-LW){1'b0}}, r_q.flen};
            default: rdata = '0;
        endcase
    end

    assign flen = r_q.flen;
    assign irq  = |r_q.flags;

    // R7: a set flag that is not cleared stays set
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(r_q.flags) & ~$past(clr_v)) & ~r_q.flags) == '0));

    // R6: a flag rises only from an enabled edge
    a_r6_flag_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.flags & ~$past(r_q.flags) & ~$past(set_v)) == '0));

    // R8: a simultaneous set and clear leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_v & clr_v)) |=> (($past(set_v & clr_v) & ~r_q.flags) == '0));
endmodule

// File: rtl/irqf_top.sv
module irqf_top
    import irqf_pkg::*;
#(
    parameter int CH = CH_N,
    parameter int LW = LEN_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] pin_i,
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o
);
    logic [CH-1:0] sync_q;
    logic [CH-1:0] rise_ev;
    logic [CH-1:0] fall_ev;
    logic [LW-1:0] flen;

    irqf_sync #(.W(CH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_i),
        .q     (sync_q)
    );

    for (genvar c = 0; c < CH; c++) begin : g_chan
        irqf_filter #(.LEN_W(LW)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (sync_q[c]),
            .flen   (flen),
            .rise   (rise_ev[c]),
            .fall   (fall_ev[c])
        );
    end

    irqf_regs #(.CH(CH), .LW(LW), .AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr_i),
        .we      (we_i),
        .wdata   (wdata_i),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .rdata   (rdata_o),
        .flen    (flen),
        .irq     (irq_o)
    );
endmodule

// File: tb/irqf_top_tb.sv
module irqf_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_REN = 8'h28;
    localparam logic [7:0] A_FEN = 8'h2C;
    localparam logic [7:0] A_EVT = 8'h30;
    localparam logic [7:0] A_FLT = 8'h34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irqf_top u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin),
        .addr_i  (addr),
        .we_i    (we),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    // monitor: compares each queued expectation shortly after the negedge it was pushed on
    always @(negedge clk) begin
        #2;
        while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            act = it.is_irq ? {31'b0, irq} : rdata;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        we = 1'b0;
        addr = a;
        it.is_irq = 1'b0;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1;
        it.exp = {31'b0, e};
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1;
        addr = a;
        wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk);
        pin[i] = v;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(A_REN, 32'h0, "R1 rise enable reset");
        rd(A_FEN, 32'h0, "R1 fall enable reset");
        rd(A_EVT, 32'h0, "R1 flags reset");
        rd(A_FLT, 32'h0, "R1 filter reset");
        chk_irq(1'b0, "R1 irq reset");

        // enable registers, reserved bits
        wr(A_REN, 32'hFFFF_FFFF);
        rd(A_REN, 32'h0000_FFFF, "R2 rise enable upper bits");
        wr(A_FEN, 32'hABCD_1234);
        rd(A_FEN, 32'h0000_1234, "R2 fall enable upper bits");
        wr(A_REN, 32'h0000_0001);
        wr(A_FEN, 32'h0000_0000);

        // unmapped offsets
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R10 unmapped read");
        rd(A_REN, 32'h1, "R10 unmapped write ignored");

        // filter length field
        wr(A_FLT, 32'hFFFF_FFF7);
        rd(A_FLT, 32'h7, "R3 filter field width");
        wr(A_FLT, 32'h0);

        // L=0 timing: flag on third edge after the change
        set_pin(0, 1'b1);
        cyc(2);
        rd(A_EVT, 32'h0, "R5 L0 not before edge 3");
        cyc(1);
        rd(A_EVT, 32'h1, "R5 L0 flag on edge 3");
        chk_irq(1'b1, "R9 irq with flag");
        wr(A_EVT, 32'h1);
        rd(A_EVT, 32'h0, "R7 write one clears");
        chk_irq(1'b0, "R9 irq low after clear");
        set_pin(0, 1'b0);
        cyc(6);
        rd(A_EVT, 32'h0, "R6 falling edge ignored without enable");

        // L=3: 3-cycle glitch rejected, 4-cycle pulse accepted
        wr(A_FLT, 32'h3);
        set_pin(0, 1'b1);
        cyc(3);
        @(negedge clk);
        pin[0] = 1'b0;
        cyc(10);
        rd(A_EVT, 32'h0, "R4 glitch of L cycles rejected");
        set_pin(0, 1'b1);
        cyc(4);
        @(negedge clk);
        pin[0] = 1'b0;
        cyc(1);
        rd(A_EVT, 32'h0, "R5 L3 not before edge 6");
        cyc(1);
        rd(A_EVT, 32'h1, "R5 L3 flag on edge 6");
        cyc(10);
        wr(A_EVT, 32'h0);
        rd(A_EVT, 32'h1, "R7 write zero keeps flag");
        wr(A_EVT, 32'hFFFF);
        rd(A_EVT, 32'h0, "R7 clear all");

        // dual-edge on pin 2, falling-only on pin 3
        wr(A_FLT, 32'h0);
        wr(A_REN, 32'h0000_0004);
        wr(A_FEN, 32'h0000_000C);
        set_pin(2, 1'b1);
        cyc(5);
        rd(A_EVT, 32'h4, "R6 dual pin rising");
        wr(A_EVT, 32'h4);
        set_pin(2, 1'b0);
        cyc(5);
        rd(A_EVT, 32'h4, "R6 dual pin falling");
        wr(A_EVT, 32'h4);
        set_pin(3, 1'b1);
        cyc(5);
        rd(A_EVT, 32'h0, "R6 fall-only pin ignores rise");
        set_pin(3, 1'b0);
        cyc(5);
        rd(A_EVT, 32'h8, "R6 fall-only pin falling");

        // disabling enables keeps flags
        wr(A_REN, 32'h0);
        wr(A_FEN, 32'h0);
        rd(A_EVT, 32'h8, "R9 flags kept after enable change");
        chk_irq(1'b1, "R9 irq kept after enable change");
        wr(A_EVT, 32'h8);
        chk_irq(1'b0, "R9 irq low after last clear");

        // two pins at once
        wr(A_REN, 32'h0000_0070);
        @(negedge clk);
        pin[5] = 1'b1;
        pin[6] = 1'b1;
        cyc(5);
        rd(A_EVT, 32'h60, "R6 two pins together");
        wr(A_EVT, 32'h60);

        // set wins over clear: pin 4 flag preset, then edge and clear in one cycle
        set_pin(4, 1'b1);
        cyc(5);
        rd(A_EVT, 32'h10, "R6 pin4 preset flag");
        set_pin(4, 1'b0);
        cyc(5);
        @(negedge clk);
        pin[4] = 1'b1;
        cyc(2);
        @(negedge clk);
        we = 1'b1;
        addr = A_EVT;
        wdata = 32'h10;
        @(negedge clk);
        we = 1'b0;
        rd(A_EVT, 32'h10, "R8 set wins over clear");

        cyc(3);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule